// File: doc/BRIEF.md
# Synchronous Bus Master with Wait-State Timeout

This block turns single transfer requests from local logic into read or write cycles on a shared, clocked bus. A request is accepted with a valid/ready handshake. The master then drives address, direction and, for writes, the write data onto the bus. It keeps all of them steady until the addressed target raises its ready line. The number of cycles a transfer takes therefore depends on how quickly the target answers.

When the target answers, the master captures read data in that same cycle, pulses `done` and goes back to idle. A wait counter limits how long it will hold the bus. If the target stays silent for the full timeout window, the master gives up, pulses `error` and goes back to idle. Back-pressure on the request side is simple. `req_ready` is high only while no transfer is in flight. A request offered while `req_ready` is low is not taken and leaves no trace. The result outputs (`done`, `error`, `rd_data`) are plain status and take no back-pressure.

Top module: `sync_bus_master`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_cmd_valid`, `done` and `error` are 0, and `bus_addr`, `bus_rnw`, `bus_wdata` and `rd_data` are all 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle, `bus_cmd_valid` is 1 and `bus_rnw` carries the direction: 1 means read, 0 means write.
- R3: While the command is on the bus, `bus_addr` holds the accepted address. `bus_wdata` holds the accepted write data for a write and is 0 for a read. Both stay unchanged until the transfer ends.
- R4: For a read, `rd_data` takes the value of `bus_rdata` on the edge where `slave_ready` is 1 during the command. `rd_data` then holds that value until the next read completes; writes and aborted transfers leave it unchanged.
- R5: In the cycle after the completing edge, `done` is 1 for exactly one cycle and `bus_cmd_valid` is 0.
- R6: The parameter TIMEOUT (default 16) sets the wait window. A transfer whose `slave_ready` is 0 in all TIMEOUT command cycles is aborted: `error` is 1 for one cycle, `bus_cmd_valid` drops, and `done` stays 0. If `slave_ready` is 1 in the TIMEOUT-th command cycle, the transfer completes normally.
- R7: While idle, the bus outputs stay 0, and `slave_ready` and `bus_rdata` have no effect on any output.
- R8: While a transfer is in flight, `req_ready` is 0 and `req_valid` is ignored.
- R9: A new request can be accepted on the edge right after the completing one, that is, during the `done` cycle, so transfers can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request offered |
| req_ready | output | 1 | Master idle, request will be taken |
| req_addr | input | AW | Request address |
| req_rnw | input | 1 | Request direction, 1 = read, 0 = write |
| req_wdata | input | DW | Request write data |
| done | output | 1 | One-cycle pulse, transfer completed |
| error | output | 1 | One-cycle pulse, transfer aborted on timeout |
| rd_data | output | DW | Data of the last completed read |
| bus_cmd_valid | output | 1 | Command present on the bus |
| bus_addr | output | AW | Bus address |
| bus_rnw | output | 1 | Bus direction, 1 = read, 0 = write |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data from target |
| slave_ready | input | 1 | Target response, valid data on the bus |

## Verification
Every result is due one cycle after the edge that causes it. The bus command appears in the cycle after acceptance. `done`, `error` and the new `rd_data` appear in the cycle after the edge that ends the transfer, and the timeout falls due on the TIMEOUT-th command cycle. The bench keeps a behavioural model that steps on the same rising edge, using only input values that were driven at the falling edge. It compares every output at the next falling edge, so each due cycle is checked exactly once. The bench also checks the edge case where the target answers in the last allowed cycle against the case where it answers one cycle later.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [0:0] {
    SBM_IDLE = 1'b0,
    SBM_WAIT = 1'b1
  } sbm_state_e;

  function automatic int unsigned sbm_cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/sbm_wait_timer.sv
module sbm_wait_timer #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic expired
);
  localparam int unsigned CW = sbm_pkg::sbm_cnt_width(TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (active && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = active && (cnt_q == LAST);

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= LAST)); // R6
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic slave_ready,
  input  logic expired,
  output logic req_ready,
  output logic accept,
  output logic in_wait,
  output logic finish,
  output logic done,
  output logic error
);
  import sbm_pkg::*;

  sbm_state_e state_q, state_d;
  logic       abort;

  assign in_wait   = (state_q == SBM_WAIT);
  assign req_ready = (state_q == SBM_IDLE);
  assign accept    = req_ready && req_valid;
  assign finish    = in_wait && slave_ready;
  assign abort     = in_wait && !slave_ready && expired;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SBM_IDLE: if (accept) state_d = SBM_WAIT;
      SBM_WAIT: if (finish || abort) state_d = SBM_IDLE;
      default:  state_d = SBM_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SBM_IDLE;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= finish;
      error   <= abort;
    end
  end

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R6
  AST_DONE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && slave_ready) |=> (done && !in_wait)); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !req_ready); // R8
endmodule

// File: rtl/sbm_datapath.sv
module sbm_datapath #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          in_wait,
  input  logic          finish,
  input  logic [AW-1:0] req_addr,
  input  logic          req_rnw,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rnw,
  output logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rd_data
);
  logic [AW-1:0] addr_q;
  logic          rnw_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rnw_q   <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      rnw_q   <= req_rnw;
      wdata_q <= req_rnw ? '0 : req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (finish && rnw_q) begin
      rdata_q <= bus_rdata;
    end
  end

  assign bus_addr  = in_wait ? addr_q  : '0;
  assign bus_rnw   = in_wait ? rnw_q   : 1'b0;
  assign bus_wdata = in_wait ? wdata_q : '0;
  assign rd_data   = rdata_q;

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !finish) |=> (!in_wait || ($stable(bus_addr) && $stable(bus_rnw)
                                           && $stable(bus_wdata)))); // R3
  AST_RD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(finish && rnw_q) |=> $stable(rd_data)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_wait |-> (bus_addr == '0 && bus_wdata == '0 && !bus_rnw)); // R7
endmodule

// File: rtl/sync_bus_master.sv
module sync_bus_master #(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_rnw,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          error,
  output logic [DW-1:0] rd_data,
  output logic          bus_cmd_valid,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rnw,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          slave_ready
);
  logic accept;
  logic in_wait;
  logic finish;
  logic expired;

  sbm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .slave_ready(slave_ready),
    .expired    (expired),
    .req_ready  (req_ready),
    .accept     (accept),
    .in_wait    (in_wait),
    .finish     (finish),
    .done       (done),
    .error      (error)
  );

  sbm_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .active (in_wait),
    .expired(expired)
  );

  sbm_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .in_wait  (in_wait),
    .finish   (finish),
    .req_addr (req_addr),
    .req_rnw  (req_rnw),
    .req_wdata(req_wdata),
    .bus_rdata(bus_rdata),
    .bus_addr (bus_addr),
    .bus_rnw  (bus_rnw),
    .bus_wdata(bus_wdata),
    .rd_data  (rd_data)
  );

  assign bus_cmd_valid = in_wait;

  AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_cmd_valid); // R2
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> !(done || error)); // R5
endmodule

// File: tb/tb_sync_bus_master.sv
`timescale 1ns/1ps
module tb_sync_bus_master;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_rnw = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          done, error;
  logic [DW-1:0] rd_data;
  logic          bus_cmd_valid;
  logic [AW-1:0] bus_addr;
  logic          bus_rnw;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          slave_ready = 1'b0;

  always #2.5 clk = ~clk;

  sync_bus_master #(.AW(AW), .DW(DW), .TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rnw(req_rnw), .req_wdata(req_wdata),
    .done(done), .error(error), .rd_data(rd_data),
    .bus_cmd_valid(bus_cmd_valid), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slave_ready(slave_ready)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference, stepped on the rising edge from stable inputs.
  bit            started = 0;
  bit            m_busy = 0, m_rnw = 0, m_done = 0, m_err = 0;
  int            m_cnt = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_busy = 0; m_rnw = 0; m_done = 0; m_err = 0; m_cnt = 0;
      m_addr = '0; m_wd = '0; m_rd = '0;
    end else begin
      m_done = 0; m_err = 0;
      if (!m_busy) begin
        if (req_valid) begin
          m_busy = 1; m_cnt = 1; m_addr = req_addr; m_rnw = req_rnw;
          m_wd = req_rnw ? '0 : req_wdata;
        end
      end else if (slave_ready) begin
        m_busy = 0; m_done = 1;
        if (m_rnw) m_rd = bus_rdata;
      end else if (m_cnt == TO) begin
        m_busy = 0; m_err = 1;
      end else begin
        m_cnt++;
      end
    end
  end

  // Per-cycle comparison at the falling edge.
  bit saw_done = 0, saw_err = 0;
  always @(negedge clk) begin
    if (started) begin
      chk("R2", "bus_cmd_valid", bus_cmd_valid, m_busy);
      chk("R2", "bus_rnw", bus_rnw, m_busy ? m_rnw : 1'b0);
      chk("R3", "bus_addr", bus_addr, m_busy ? m_addr : '0);
      chk("R3", "bus_wdata", bus_wdata, m_busy ? m_wd : '0);
      chk("R4", "rd_data", rd_data, m_rd);
      chk("R5", "done", done, m_done);
      chk("R6", "error", error, m_err);
      chk("R8", "req_ready", req_ready, !m_busy);
      if (done)  saw_done = 1;
      if (error) saw_err  = 1;
    end
  end

  // Target model: answers after lat waiting cycles.
  int            lat = 0;
  int            seen = 0;
  logic [DW-1:0] rsp_val = '0;
  bit            idle_sr = 0;
  logic [DW-1:0] idle_rd = '0;
  always @(negedge clk) begin
    if (bus_cmd_valid === 1'b1) begin
      if (seen == lat) begin
        slave_ready <= 1'b1; bus_rdata <= rsp_val;
      end else begin
        slave_ready <= 1'b0; bus_rdata <= 32'hDEAD_BEEF;
      end
      seen++;
    end else begin
      seen = 0;
      slave_ready <= idle_sr; bus_rdata <= idle_rd;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bus_cmd_valid !== 1'b1) break;
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input bit rnw, input logic [DW-1:0] wd,
                       input int l, input logic [DW-1:0] rv);
    lat = l; rsp_val = rv; saw_done = 0; saw_err = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_rnw = rnw; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    wait_idle();
    @(negedge clk);
    if (l < TO) begin
      chk("R5", "done seen", saw_done, 1'b1);
      chk("R6", "no error", saw_err, 1'b0);
    end else begin
      chk("R6", "error seen", saw_err, 1'b1);
      chk("R6", "no done", saw_done, 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", req_ready, 1'b1);
    chk("R1", "bus_cmd_valid", bus_cmd_valid, 1'b0);
    chk("R1", "done|error", {done, error}, 2'b00);
    chk("R1", "bus_addr", bus_addr, '0);
    chk("R1", "bus_rnw", bus_rnw, 1'b0);
    chk("R1", "bus_wdata", bus_wdata, '0);
    chk("R1", "rd_data", rd_data, '0);
    rst_n = 1;

    issue(32'h0000_1000, 1, 32'h5555, 0, 32'h0000_0011);
    chk("R4", "read lat0", rd_data, 32'h11);
    issue(32'h0000_2004, 1, '0, 3, 32'hCAFE_0003);
    chk("R4", "read lat3", rd_data, 32'hCAFE_0003);
    issue(32'h0000_3008, 0, 32'hA5A5_1234, 2, 32'h0BAD_0BAD);
    chk("R4", "write keeps rd", rd_data, 32'hCAFE_0003);
    issue(32'h0000_400C, 1, '0, TO - 1, 32'h1234_5678);
    chk("R6", "last-cycle answer", rd_data, 32'h1234_5678);
    issue(32'h0000_5010, 1, '0, TO, 32'h9999_9999);
    chk("R6", "abort keeps rd", rd_data, 32'h1234_5678);
    issue(32'h0000_6014, 0, 32'h7777_7777, 1000, '0);

    // R8: requests during a transfer are ignored
    lat = 6; rsp_val = 32'h6666_0006;
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0000_7000; req_rnw = 1;
    @(negedge clk);
    req_addr = 32'h0000_7FF0; req_rnw = 0; req_wdata = 32'hFFFF;
    @(negedge clk);
    chk("R8", "busy req_ready", req_ready, 1'b0);
    chk("R8", "addr unchanged", bus_addr, 32'h0000_7000);
    req_valid = 0;
    wait_idle();
    chk("R8", "read after ignore", rd_data, 32'h6666_0006);

    // R7: target activity while idle has no effect
    idle_sr = 1; idle_rd = 32'h0000_0077;
    repeat (4) @(negedge clk);
    chk("R7", "idle rd_data", rd_data, 32'h6666_0006);
    chk("R7", "idle done", done, 1'b0);
    chk("R7", "idle bus_addr", bus_addr, '0);
    idle_sr = 0; idle_rd = '0;
    @(negedge clk);

    // R9: back-to-back acceptance in the done cycle
    lat = 2; rsp_val = 32'hB2B0_0001;
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0000_8000; req_rnw = 1;
    @(negedge clk);
    req_addr = 32'h0000_9000; req_rnw = 0; req_wdata = 32'h0000_0B0B;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (done === 1'b1) break;
    end
    chk("R9", "ready in done cycle", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 0;
    chk("R9", "next cmd valid", bus_cmd_valid, 1'b1);
    chk("R9", "next cmd addr", bus_addr, 32'h0000_9000);
    chk("R9", "next cmd wdata", bus_wdata, 32'h0000_0B0B);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R4", "b2b read value", rd_data, 32'hB2B0_0001);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule